// File: doc/BRIEF.md
# Radio Module Power-Up Sequencer

This controller sits on the host side of an attached wireless radio module. It brings the module from unpowered to running and back again. It owns the module's active-low reset pin and its power-enable pin. It counts rising edges of a free-running 32.768 kHz sleep clock, which it resynchronises into the system clock domain, and it times the supply-settling wait with a counter on the system clock. Wake-up does not use a pin. The sequencer asks a separate host-interface master to write a register that sets, and later clears, the module's wake bit. It then waits until the module's ready status bit and its interrupt line are both high.

The host raises `pwr_on_req` to start a power-up and lowers it to request a power-down. Once the module reports ready, the sequencer hands the bus to the firmware loader through `fw_go`. It stays in that hand-off until `fw_done` arrives, then clears the wake bit and reports the running state. If ready does not arrive within a parameterised window, the sequencer parks in an error state and raises a sticky flag. A power-down always holds the module in reset for a counted number of sleep-clock periods before it removes the supply enable.

The state is reported on a 3-bit status output with these codes: 0 off, 1 reset, 2 settling, 3 waking, 4 ready, 5 download, 6 running, 7 error.

Top module: `radio_pwrseq`

## Requirements
- R1: While the block reset `rst_n` is low, and directly after it, `mod_rst_n`, `mod_pwr_en`, `wr_req`, `fw_go` and `err_flag` are 0 and `seq_status` is 0 (off).
- R2: After `pwr_on_req` rises, `seq_status` is 1 and `mod_rst_n` stays low until SLK_CYCLES+1 rising edges of `slk_in` have been counted while `io_pwr_good` is high. Any cycle with `io_pwr_good` low restarts the count. Release therefore comes no earlier than SLK_CYCLES full sleep-clock periods after the I/O supply is good.
- R3: `mod_pwr_en` rises in the same cycle that `mod_rst_n` is released, never later and never before. While `mod_rst_n` is high, `mod_pwr_en` is high.
- R4: After reset release, `seq_status` is 2 for exactly SETTLE_CYC = CLK_HZ*SETTLE_US/1e6 cycles, and no write is requested during that time.
- R5: Next, `seq_status` is 3 and `wr_req` is high with `wr_set`=1 (set the wake bit). The request holds steady until a cycle in which `wr_ack` is high.
- R6: After that acknowledge, the first cycle in which `rdy_bit` and `mod_irq` are both high moves to `seq_status` 4 for one cycle. After that, `seq_status` is 5 with `fw_go` high.
- R7: If no such cycle falls within the first TMO_CYC = CLK_HZ*READY_TMO_US/1e6 cycles of the ready wait, `seq_status` becomes 7 and `err_flag` becomes 1. Ready in the last cycle of the window still wins.
- R8: A `fw_done` pulse during download drops `fw_go` and raises `wr_req` with `wr_set`=0 (clear the wake bit) while `seq_status` stays 5. The cycle after `wr_ack`, `seq_status` is 6.
- R9: `pwr_on_req` low in any state past reset release (including error) gives `seq_status` 1, `mod_rst_n` low and `mod_pwr_en` still high. This lasts until SLK_CYCLES+1 sleep-clock rising edges have been counted, and only then does it reach status 0 with the enable low. From status 1 during power-up, it returns to 0 at once. A power-down request wins over a ready indication in the same cycle.
- R10: `err_flag` stays 1 through the power-down and in the off state. It clears only when the next power-up starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| pwr_on_req | input | 1 | High requests the module powered and running, low requests power-down |
| io_pwr_good | input | 1 | I/O supply of the module is up |
| slk_in | input | 1 | 32.768 kHz sleep clock, asynchronous |
| rdy_bit | input | 1 | Ready status bit reported by the host-interface master |
| mod_irq | input | 1 | Interrupt line from the module, active high |
| wr_ack | input | 1 | Host-interface master has completed the requested write |
| fw_done | input | 1 | Firmware loader has finished |
| mod_rst_n | output | 1 | Reset pin to the module, active low |
| mod_pwr_en | output | 1 | Power-enable pin to the module, high = on |
| wr_req | output | 1 | Request a wake-bit register write |
| wr_set | output | 1 | Value of the wake bit for the write: 1 set, 0 clear |
| fw_go | output | 1 | Firmware download may proceed |
| err_flag | output | 1 | Sticky ready-timeout flag |
| seq_status | output | 3 | Current state code, listed above |

## Verification
Two pairs of events can fall in the same cycle. The first is the ready indication and the expiry of the ready timeout. The second is the ready indication and a power-down request. The vector table places `rdy_bit`/`mod_irq` at exact offsets from the write acknowledge: the last window cycle, which must end in download, and one cycle later, which must end in error. A further vector drops `pwr_on_req` in the very cycle ready arrives, and the result is judged by the status code, pin levels and error flag sampled well after the event. That vector must show the reset state with the enable still high and no error.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    S_OFF,
    S_HOLD,
    S_SETTLE,
    S_WAKE_WR,
    S_WAKE_WAIT,
    S_READY,
    S_DL,
    S_CLR_WR,
    S_RUN,
    S_ERR,
    S_PDOWN
  } seq_st_t;

  localparam logic [2:0] ST_OFF    = 3'd0;
  localparam logic [2:0] ST_RESET  = 3'd1;
  localparam logic [2:0] ST_SETTLE = 3'd2;
  localparam logic [2:0] ST_WAKE   = 3'd3;
  localparam logic [2:0] ST_READY  = 3'd4;
  localparam logic [2:0] ST_DL     = 3'd5;
  localparam logic [2:0] ST_RUN    = 3'd6;
  localparam logic [2:0] ST_ERROR  = 3'd7;

  // Cycles of a clock of hz hertz that cover us microseconds.
  function automatic longint unsigned us_to_cycles(input longint unsigned hz,
                                                   input longint unsigned us);
    return (hz * us) / 64'd1_000_000;
  endfunction

  // Externally visible status code for an internal state.
  function automatic logic [2:0] status_of(input seq_st_t s);
    case (s)
      S_OFF:                  return ST_OFF;
      S_HOLD, S_PDOWN:        return ST_RESET;
      S_SETTLE:               return ST_SETTLE;
      S_WAKE_WR, S_WAKE_WAIT: return ST_WAKE;
      S_READY:                return ST_READY;
      S_DL, S_CLR_WR:         return ST_DL;
      S_RUN:                  return ST_RUN;
      default:                return ST_ERROR;
    endcase
  endfunction

  // Module pins are out of reset only in the operating states.
  function automatic logic released(input seq_st_t s);
    return (s == S_SETTLE) || (s == S_WAKE_WR) || (s == S_WAKE_WAIT) ||
           (s == S_READY)  || (s == S_DL)      || (s == S_CLR_WR)    ||
           (s == S_RUN);
  endfunction

  // Supply enable covers the operating states plus error and power-down.
  function automatic logic powered(input seq_st_t s);
    return released(s) || (s == S_ERR) || (s == S_PDOWN);
  endfunction

endpackage

// File: rtl/pwrseq_slk_edge.sv
module pwrseq_slk_edge #(
  parameter int SYNC_STAGES = 2,
  parameter int NEED        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slk_in,
  input  logic count_en,
  output logic reached
);
  localparam int CW = $clog2(NEED + 1);
  localparam logic [CW-1:0] LAST = CW'(NEED - 1);

  logic [SYNC_STAGES:0] sh_q;
  logic                 slk_rise;
  logic [CW-1:0]        cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], slk_in};
  end

  assign slk_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign reached  = count_en && slk_rise && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!count_en)        cnt_q <= '0;
    else if (reached)          cnt_q <= '0;
    else if (slk_rise)         cnt_q <= cnt_q + 1'b1;
  end

  // R2
  edge_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] last,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  assign done = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || done)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R4 R7
  tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= last);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       slk_reached,
  input  logic       tmr_done,
  input  logic       wr_ack,
  input  logic       rdy_bit,
  input  logic       mod_irq,
  input  logic       fw_done,
  output seq_st_t    state_o,
  output logic       mod_rst_n_o,
  output logic       mod_pwr_en_o,
  output logic       wr_req_o,
  output logic       wr_set_o,
  output logic       fw_go_o,
  output logic       err_o,
  output logic [2:0] status_o
);
  seq_st_t state_q, state_d;
  logic    err_q;
  logic    down_req;
  logic    ready_seen;
  logic    start_evt;
  logic    err_set;

  assign down_req   = !pwr_on_req;
  assign ready_seen = rdy_bit && mod_irq;
  assign start_evt  = (state_q == S_OFF) && pwr_on_req;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_OFF:       if (pwr_on_req) state_d = S_HOLD;
      S_HOLD:      if (down_req) state_d = S_OFF;
                   else if (slk_reached) state_d = S_SETTLE;
      S_SETTLE:    if (down_req) state_d = S_PDOWN;
                   else if (tmr_done) state_d = S_WAKE_WR;
      S_WAKE_WR:   if (down_req) state_d = S_PDOWN;
                   else if (wr_ack) state_d = S_WAKE_WAIT;
      S_WAKE_WAIT: if (down_req) state_d = S_PDOWN;
                   else if (ready_seen) state_d = S_READY;
                   else if (tmr_done) state_d = S_ERR;
      S_READY:     if (down_req) state_d = S_PDOWN;
                   else state_d = S_DL;
      S_DL:        if (down_req) state_d = S_PDOWN;
                   else if (fw_done) state_d = S_CLR_WR;
      S_CLR_WR:    if (down_req) state_d = S_PDOWN;
                   else if (wr_ack) state_d = S_RUN;
      S_RUN:       if (down_req) state_d = S_PDOWN;
      S_ERR:       if (down_req) state_d = S_PDOWN;
      S_PDOWN:     if (slk_reached) state_d = S_OFF;
      default:     state_d = S_OFF;
    endcase
  end

  assign err_set = (state_q == S_WAKE_WAIT) && (state_d == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (err_set)        err_q <= 1'b1;
      else if (start_evt) err_q <= 1'b0;
    end
  end

  assign state_o      = state_q;
  assign mod_rst_n_o  = released(state_q);
  assign mod_pwr_en_o = powered(state_q);
  assign wr_req_o     = (state_q == S_WAKE_WR) || (state_q == S_CLR_WR);
  assign wr_set_o     = (state_q == S_WAKE_WR);
  assign fw_go_o      = (state_q == S_DL);
  assign err_o        = err_q;
  assign status_o     = status_of(state_q);

  // R3
  pwr_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst_n_o |-> mod_pwr_en_o);

  // R3
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_pwr_en_o) |-> mod_rst_n_o);

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !wr_ack && pwr_on_req |=> wr_req_o && $stable(wr_set_o));

  // R6
  fw_go_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fw_go_o) |-> $past(status_o) == ST_READY);

  // R7
  err_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> status_o == ST_ERROR);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !start_evt |=> err_o);

  // R9
  off_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o == ST_OFF |-> !mod_pwr_en_o && !mod_rst_n_o);

endmodule

// File: rtl/radio_pwrseq.sv
module radio_pwrseq
  import pwrseq_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned SETTLE_US    = 30_000,
  parameter int unsigned READY_TMO_US = 100_000,
  parameter int unsigned SLK_CYCLES   = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       io_pwr_good,
  input  logic       slk_in,
  input  logic       rdy_bit,
  input  logic       mod_irq,
  input  logic       wr_ack,
  input  logic       fw_done,
  output logic       mod_rst_n,
  output logic       mod_pwr_en,
  output logic       wr_req,
  output logic       wr_set,
  output logic       fw_go,
  output logic       err_flag,
  output logic [2:0] seq_status
);
  localparam longint unsigned SETTLE_CYC = us_to_cycles(64'(CLK_HZ), 64'(SETTLE_US));
  localparam longint unsigned TMO_CYC    = us_to_cycles(64'(CLK_HZ), 64'(READY_TMO_US));
  localparam longint unsigned SPAN       = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC;
  localparam int              TW         = $clog2(SPAN + 1);
  localparam logic [TW-1:0]   SETTLE_LAST = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0]   TMO_LAST    = TW'(TMO_CYC - 1);
  localparam int              EDGE_NEED   = int'(SLK_CYCLES) + 1;

  seq_st_t       state;
  logic          edge_count_en;
  logic          slk_reached;
  logic          tmr_run;
  logic          tmr_done;
  logic [TW-1:0] tmr_last;

  assign edge_count_en = ((state == S_HOLD) && io_pwr_good) || (state == S_PDOWN);
  assign tmr_run       = (state == S_SETTLE) || (state == S_WAKE_WAIT);
  assign tmr_last      = (state == S_SETTLE) ? SETTLE_LAST : TMO_LAST;

  pwrseq_slk_edge #(
    .SYNC_STAGES (int'(SYNC_STAGES)),
    .NEED        (EDGE_NEED)
  ) u_slk_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .slk_in   (slk_in),
    .count_en (edge_count_en),
    .reached  (slk_reached)
  );

  pwrseq_timer #(
    .TW (TW)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tmr_run),
    .last  (tmr_last),
    .done  (tmr_done)
  );

  pwrseq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_on_req   (pwr_on_req),
    .slk_reached  (slk_reached),
    .tmr_done     (tmr_done),
    .wr_ack       (wr_ack),
    .rdy_bit      (rdy_bit),
    .mod_irq      (mod_irq),
    .fw_done      (fw_done),
    .state_o      (state),
    .mod_rst_n_o  (mod_rst_n),
    .mod_pwr_en_o (mod_pwr_en),
    .wr_req_o     (wr_req),
    .wr_set_o     (wr_set),
    .fw_go_o      (fw_go),
    .err_o        (err_flag),
    .status_o     (seq_status)
  );

  // R4
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SETTLE |-> !wr_req && !fw_go);

endmodule

// File: tb/test_radio_pwrseq.sv
module test_radio_pwrseq;

  localparam int CLK_HZ   = 1_000_000;
  localparam int SET_US   = 50;
  localparam int TMO_US   = 20;
  localparam int SET_CYC  = CLK_HZ / 1_000_000 * SET_US;
  localparam int TMO_CYC  = CLK_HZ / 1_000_000 * TMO_US;
  localparam int SLK_HALF = 6;
  localparam int SLK_PER  = 2 * SLK_HALF;
  localparam int MIN_HOLD = 2 * SLK_PER;
  localparam int MAX_HOLD = 3 * SLK_PER + 4;

  // ready-wait vectors: delay, irq with ready, power-down in that cycle,
  // expected status code, expected error flag
  localparam int NV = 6;
  localparam int V_DLY  [NV] = '{0, 7, TMO_CYC - 1, TMO_CYC, 3, 2};
  localparam int V_IRQ  [NV] = '{1, 1, 1,           1,       0, 1};
  localparam int V_DROP [NV] = '{0, 0, 0,           0,       0, 1};
  localparam int V_STAT [NV] = '{5, 5, 5,           7,       7, 1};
  localparam int V_ERR  [NV] = '{0, 0, 0,           1,       1, 0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_on_req = 1'b0;
  logic       io_pwr_good = 1'b0;
  logic       slk_in = 1'b0;
  logic       rdy_bit = 1'b0;
  logic       mod_irq = 1'b0;
  logic       wr_ack = 1'b0;
  logic       fw_done = 1'b0;
  logic       mod_rst_n, mod_pwr_en, wr_req, wr_set, fw_go, err_flag;
  logic [2:0] seq_status;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  radio_pwrseq #(
    .CLK_HZ       (CLK_HZ),
    .SETTLE_US    (SET_US),
    .READY_TMO_US (TMO_US),
    .SLK_CYCLES   (2),
    .SYNC_STAGES  (2)
  ) i_radio_pwrseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_on_req  (pwr_on_req),
    .io_pwr_good (io_pwr_good),
    .slk_in      (slk_in),
    .rdy_bit     (rdy_bit),
    .mod_irq     (mod_irq),
    .wr_ack      (wr_ack),
    .fw_done     (fw_done),
    .mod_rst_n   (mod_rst_n),
    .mod_pwr_en  (mod_pwr_en),
    .wr_req      (wr_req),
    .wr_set      (wr_set),
    .fw_go       (fw_go),
    .err_flag    (err_flag),
    .seq_status  (seq_status)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      repeat (SLK_HALF) @(negedge clk);
      slk_in = ~slk_in;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input string what, input int act,
                           input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_off();
    for (int i = 0; i < 300 && seq_status != 3'd0; i++) @(negedge clk);
  endtask

  task automatic up_to_wake();
    pwr_on_req = 1'b1;
    @(negedge clk);
    chk("R10", "error cleared at power-up start", int'(err_flag), 0);
    for (int i = 0; i < 600 && !wr_req; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int n;
    bit prev_en;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "status in reset", int'(seq_status), 0);
    chk("R1", "pins in reset", int'({mod_rst_n, mod_pwr_en, wr_req, fw_go, err_flag}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "status after reset", int'(seq_status), 0);

    // R2: hold while I/O supply is down
    pwr_on_req = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2", "status with io down", int'(seq_status), 1);
    chk("R2", "reset held with io down", int'(mod_rst_n), 0);
    chk("R3", "enable off before release", int'(mod_pwr_en), 0);
    io_pwr_good = 1'b1;
    n = 0;
    prev_en = mod_pwr_en;
    while (!mod_rst_n && n < 200) begin
      prev_en = mod_pwr_en;
      @(negedge clk);
      n++;
    end
    chk_range("R2", "cycles to reset release", n, MIN_HOLD, MAX_HOLD);
    chk("R3", "enable with release", int'(mod_pwr_en), 1);
    chk("R3", "enable before release", int'(prev_en), 0);

    // R4: settle length
    n = 0;
    while (!wr_req && n < 1000) begin
      if (seq_status == 3'd2) n++;
      @(negedge clk);
    end
    chk("R4", "settle cycles", n, SET_CYC);

    // R5: wake write held until ack
    chk("R5", "status waking", int'(seq_status), 3);
    chk("R5", "wr_set for wake", int'(wr_set), 1);
    repeat (3) @(negedge clk);
    chk("R5", "request held without ack", int'({wr_req, wr_set}), 3);
    wr_ack = 1'b1;
    @(negedge clk);
    wr_ack = 1'b0;
    rdy_bit = 1'b1;
    mod_irq = 1'b1;
    @(negedge clk);
    chk("R6", "ready status", int'(seq_status), 4);
    rdy_bit = 1'b0;
    mod_irq = 1'b0;
    @(negedge clk);
    chk("R6", "download status", int'(seq_status), 5);
    chk("R6", "fw_go", int'(fw_go), 1);

    // R8: clear write
    fw_done = 1'b1;
    @(negedge clk);
    fw_done = 1'b0;
    chk("R8", "clear write req/set/go", int'({wr_req, wr_set, fw_go}), 4);
    chk("R8", "status during clear", int'(seq_status), 5);
    wr_ack = 1'b1;
    @(negedge clk);
    wr_ack = 1'b0;
    chk("R8", "running status", int'(seq_status), 6);

    // R9: power-down from running
    pwr_on_req = 1'b0;
    @(negedge clk);
    chk("R9", "status powering down", int'(seq_status), 1);
    chk("R9", "reset low enable high", int'({mod_rst_n, mod_pwr_en}), 1);
    n = 0;
    while (mod_pwr_en && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk_range("R9", "reset-before-off cycles", n, MIN_HOLD, MAX_HOLD);
    chk("R9", "off status", int'(seq_status), 0);

    // R6 R7 R9 R10: ready-wait vector table
    for (int v = 0; v < NV; v++) begin
      up_to_wake();
      chk("R5", "wake request reached", int'(wr_req), 1);
      wr_ack = 1'b1;
      @(negedge clk);
      wr_ack = 1'b0;
      for (int k = 0; k < TMO_CYC + 3; k++) begin
        if (k == V_DLY[v]) begin
          rdy_bit = 1'b1;
          mod_irq = V_IRQ[v] != 0;
          if (V_DROP[v] != 0) pwr_on_req = 1'b0;
        end
        @(negedge clk);
      end
      chk("R7", $sformatf("vector %0d status", v), int'(seq_status), V_STAT[v]);
      chk("R7", $sformatf("vector %0d err_flag", v), int'(err_flag), V_ERR[v]);
      if (V_DROP[v] != 0)
        chk("R9", "drop beats ready: reset low enable high",
            int'({mod_rst_n, mod_pwr_en}), 1);
      rdy_bit = 1'b0;
      mod_irq = 1'b0;
      pwr_on_req = 1'b0;
      wait_off();
      chk("R9", $sformatf("vector %0d back to off", v), int'(seq_status), 0);
      chk("R10", $sformatf("vector %0d err kept in off", v), int'(err_flag), V_ERR[v]);
    end

    // R9: abort during reset hold
    pwr_on_req = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10", "err cleared by new power-up", int'(err_flag), 0);
    pwr_on_req = 1'b0;
    @(negedge clk);
    chk("R9", "abort from hold status", int'(seq_status), 0);
    chk("R9", "abort from hold enable", int'(mod_pwr_en), 0);

    finish_run();
  end

endmodule